// File: doc/BRIEF.md
# Fetch Address Redirect Selector

This combinational block picks the address that the fetch stage uses in each cycle of a short in-order pipeline for a small 64-bit instruction set. It looks at the operation codes and operands held in the decode and memory pipeline registers. If a call is being decoded, a jump turned out not to be taken, or a return has just read its target from data memory, the fetch stream is steered to the correct address. If none of these holds, fetch continues at the predicted address held in the fetch register.

The same block also works out the next prediction for the instruction fetched at the chosen address. It finds the instruction's length from its operation code and forms the sequential address from it. Jumps and calls are predicted to go to their constant target. The sequential address of a jump is still given out, so that it can travel down the pipeline in the operand-A field and be used for recovery.

Operation codes used throughout: HALT=0x0, NOP=0x1, CMOVX=0x2, IRMOVQ=0x3, RMMOVQ=0x4, MRMOVQ=0x5, OPQ=0x6, JX=0x7, CALL=0x8, RET=0x9, PUSHQ=0xA, POPQ=0xB, IOPQ=0xC. Codes 0xD to 0xF are treated as one-byte instructions.

Top module: `fetch_redirect`

## Requirements
- R1: When `dec_op` is CALL (0x8), `fetch_addr` equals `dec_const`, whatever the memory-stage fields hold.
- R2: When `dec_op` is not CALL, `mem_op` is JX (0x7) and `mem_cond` is 0, `fetch_addr` equals `mem_fall`.
- R3: When `dec_op` is not CALL and `mem_op` is RET (0x9), `fetch_addr` equals `mem_rdata`.
- R4: When none of R1 to R3 applies, `fetch_addr` equals `pred_pc`.
- R5: A jump in the memory stage with `mem_cond` 1 (taken, including the unconditional form with function 0) causes no redirect, so `fetch_addr` equals `pred_pc` unless R1 applies.
- R6: `next_seq` equals `fetch_addr` + 1, plus 1 when `fetch_op` is one of 0x2, 0x3, 0x4, 0x5, 0x6, 0xA, 0xB, 0xC (register byte), plus 8 when `fetch_op` is one of 0x3, 0x4, 0x5, 0x7, 0x8, 0xC (constant word).
- R7: When `fetch_op` is JX (0x7) or CALL (0x8), `next_pred` equals `fetch_const`.
- R8: For every other `fetch_op` (including 0xD to 0xF, which are one byte long), `next_pred` equals `next_seq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pred_pc | input | 64 | Predicted address held in the fetch register |
| dec_op | input | 4 | Operation code in the decode register |
| dec_const | input | 64 | Constant word in the decode register |
| mem_op | input | 4 | Operation code in the memory register |
| mem_cond | input | 1 | Condition result carried by the memory-stage instruction |
| mem_fall | input | 64 | Operand-A field of the memory register (fall-through address for a jump) |
| mem_rdata | input | 64 | Word read from data memory in this cycle |
| fetch_op | input | 4 | Operation code of the instruction fetched at `fetch_addr` |
| fetch_const | input | 64 | Constant word of the fetched instruction |
| fetch_addr | output | 64 | Address to fetch in this cycle |
| next_seq | output | 64 | Sequential address after the fetched instruction |
| next_pred | output | 64 | Predicted address of the next instruction |

## Verification
The selector is driven with every pair of decode and memory operation codes and both condition values. Each of the four address sources carries a different value, so any reordering of the priorities, such as a call in decode arriving together with a not-taken jump or a return in memory, shows up as the wrong source. The predictor is driven with all sixteen fetched codes at several fetch addresses, one of them near the top of the address range. This separates the four possible lengths from one another and separates target prediction from sequential prediction.

// File: rtl/fetch_redirect.sv
module fetch_redirect #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] pred_pc,
  input  logic [3:0]    dec_op,
  input  logic [AW-1:0] dec_const,
  input  logic [3:0]    mem_op,
  input  logic          mem_cond,
  input  logic [AW-1:0] mem_fall,
  input  logic [AW-1:0] mem_rdata,
  input  logic [3:0]    fetch_op,
  input  logic [AW-1:0] fetch_const,
  output logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] next_seq,
  output logic [AW-1:0] next_pred
);
  localparam logic [3:0] OP_CMOV  = 4'h2;
  localparam logic [3:0] OP_IRMOV = 4'h3;
  localparam logic [3:0] OP_RMMOV = 4'h4;
  localparam logic [3:0] OP_MRMOV = 4'h5;
  localparam logic [3:0] OP_ALU   = 4'h6;
  localparam logic [3:0] OP_JMP   = 4'h7;
  localparam logic [3:0] OP_CALL  = 4'h8;
  localparam logic [3:0] OP_RET   = 4'h9;
  localparam logic [3:0] OP_PUSH  = 4'hA;
  localparam logic [3:0] OP_POP   = 4'hB;
  localparam logic [3:0] OP_IALU  = 4'hC;

  logic call_redir, miss_redir, ret_redir;
  logic has_reg, has_const;

  assign call_redir = dec_op == OP_CALL;
  assign miss_redir = mem_op == OP_JMP && !mem_cond;
  assign ret_redir  = mem_op == OP_RET;

  always_comb begin
    if (call_redir)      fetch_addr = dec_const;
    else if (miss_redir) fetch_addr = mem_fall;
    else if (ret_redir)  fetch_addr = mem_rdata;
    else                 fetch_addr = pred_pc;
  end

  assign has_reg = fetch_op inside {OP_CMOV, OP_IRMOV, OP_RMMOV, OP_MRMOV,
                                    OP_ALU, OP_PUSH, OP_POP, OP_IALU};
  assign has_const = fetch_op inside {OP_IRMOV, OP_RMMOV, OP_MRMOV, OP_JMP,
                                      OP_CALL, OP_IALU};

  assign next_seq  = fetch_addr + AW'(1) + AW'(has_reg) + (has_const ? AW'(8) : AW'(0));
  assign next_pred = (fetch_op == OP_JMP || fetch_op == OP_CALL) ? fetch_const : next_seq;

  always_comb begin
    // R1
    call_first_chk: assert (dec_op != OP_CALL || fetch_addr == dec_const);
    // R2
    miss_recover_chk: assert (dec_op == OP_CALL || mem_op != OP_JMP || mem_cond
                              || fetch_addr == mem_fall);
    // R3
    ret_target_chk: assert (dec_op == OP_CALL || mem_op != OP_RET || fetch_addr == mem_rdata);
    // R5
    taken_quiet_chk: assert (dec_op == OP_CALL || mem_op != OP_JMP || !mem_cond
                             || fetch_addr == pred_pc);
    // R6
    length_range_chk: assert ((next_seq - fetch_addr) inside {AW'(1), AW'(2), AW'(9), AW'(10)});
    // R7
    target_pred_chk: assert (!(fetch_op inside {OP_JMP, OP_CALL}) || next_pred == fetch_const);
  end
endmodule

// File: tb/test_fetch_redirect.sv
module test_fetch_redirect;
  logic clk = 0;
  always #4 clk = ~clk;

  logic [63:0] pred_pc, dec_const, mem_fall, mem_rdata, fetch_const;
  logic [3:0]  dec_op, mem_op, fetch_op;
  logic        mem_cond;
  logic [63:0] fetch_addr, next_seq, next_pred;

  int checks = 0, failures = 0;
  bit done = 0;

  fetch_redirect i_fetch_redirect (
    .pred_pc(pred_pc), .dec_op(dec_op), .dec_const(dec_const),
    .mem_op(mem_op), .mem_cond(mem_cond), .mem_fall(mem_fall),
    .mem_rdata(mem_rdata), .fetch_op(fetch_op), .fetch_const(fetch_const),
    .fetch_addr(fetch_addr), .next_seq(next_seq), .next_pred(next_pred)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int op_len(logic [3:0] op);
    int n = 1;
    if (op inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB, 4'hC}) n += 1;
    if (op inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8, 4'hC}) n += 8;
    return n;
  endfunction

  initial begin
    pred_pc = 64'h1000; dec_const = 64'h2000; mem_fall = 64'h3000;
    mem_rdata = 64'h4000; fetch_const = 64'h5000;
    dec_op = 4'h1; mem_op = 4'h1; mem_cond = 0; fetch_op = 4'h1;
    @(negedge clk); #1;
    check("R4 idle", fetch_addr, 64'h1000);
    check("R8 idle", next_pred, 64'h1001);

    // selector sweep
    for (int d = 0; d < 16; d++)
      for (int m = 0; m < 16; m++)
        for (int c = 0; c < 2; c++) begin
          logic [63:0] exp;
          string req;
          @(negedge clk);
          dec_op = 4'(d); mem_op = 4'(m); mem_cond = c[0]; fetch_op = 4'h1;
          pred_pc = 64'h0000_0100 + 64'(d*32 + m*2 + c);
          dec_const = 64'hA000_0000 + 64'(d);
          mem_fall = 64'hB000_0000 + 64'(m);
          mem_rdata = 64'hC000_0000 + 64'(m);
          #1;
          if (d == 8) begin exp = dec_const; req = "R1"; end
          else if (m == 7 && c == 0) begin exp = mem_fall; req = "R2"; end
          else if (m == 9) begin exp = mem_rdata; req = "R3"; end
          else if (m == 7) begin exp = pred_pc; req = "R5"; end
          else begin exp = pred_pc; req = "R4"; end
          check(req, fetch_addr, exp);
        end

    // predictor sweep, fetch address taken from pred_pc
    dec_op = 4'h1; mem_op = 4'h1; mem_cond = 0;
    for (int a = 0; a < 3; a++)
      for (int f = 0; f < 16; f++) begin
        logic [63:0] base, seq;
        @(negedge clk);
        base = (a == 0) ? 64'h0 : (a == 1) ? 64'h0000_0000_0000_0123 : 64'hFFFF_FFFF_FFFF_FFF8;
        pred_pc = base; fetch_op = 4'(f);
        fetch_const = 64'h7700_0000 + 64'(f);
        #1;
        seq = base + 64'(op_len(4'(f)));
        check("R6", next_seq, seq);
        if (f == 7 || f == 8) check("R7", next_pred, fetch_const);
        else check("R8", next_pred, seq);
      end

    // predictor uses redirected address: call in decode plus not-taken jump in memory
    @(negedge clk);
    dec_op = 4'h8; dec_const = 64'h40; mem_op = 4'h7; mem_cond = 0;
    mem_fall = 64'h90; pred_pc = 64'h10; fetch_op = 4'h6;
    #1;
    check("R1 call over miss", fetch_addr, 64'h40);
    check("R6 after call", next_seq, 64'h42);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule